// File: doc/BRIEF.md
# Protected key register bank

This block stores the key material that a cipher engine consumes: one master key plus a configurable number of expanded round keys, each held as a key slot made of several host-sized words. A host loads new key words over a valid/ready write stream. A write is accepted only while a provisioning window is open. Accepted words go into a staged (shadow) copy, and a single commit request transfers the whole staged copy into the active bank in one clock edge. As a result, the cipher datapath never observes a key that is half old and half new.

The host has no path that can return key contents. A host read strobe is answered one cycle later, and the returned data is always zero. Only the internal datapath port can see keys. It selects a slot by round index and receives the full key one cycle later. When a power-loss or tamper input asserts, the active bank, the staged copy and the record of staged words are all wiped, and the key-valid status drops.

Write stream rules: a word is transferred on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low during any cycle in which `commit_req`, `power_fail` or `tamper` is high. The host must keep `wr_valid`, `wr_addr` and `wr_data` steady until the transfer happens. Only transferred words are ever checked or flagged.

Top module: `keyvault_bank`

## Requirements
- R1: After reset, `prov_open`, `key_valid`, `wr_err`, `commit_err` and `host_rd_ack` are low and `dp_key` is zero.
- R2: `prov_unlock` opens provisioning (`prov_open` high on the next cycle). `prov_lock` closes it and seals the bank, and a sealed bank ignores `prov_unlock` until reset. Lock wins over unlock in the same cycle.
- R3: A transferred write is rejected when provisioning is closed or when its address is at or beyond the word count. A rejected write changes no state, and `wr_err` pulses high in the cycle after the transfer.
- R4: A `host_rd_req` pulse is answered by `host_rd_ack` one cycle later, and `host_rd_data` is zero at all times.
- R5: A commit is refused unless every word has been written since the last successful commit or wipe. On refusal, `commit_err` pulses in the next cycle and the active bank is unchanged.
- R6: A successful commit copies the whole staged copy into the active bank on one edge, clears the record of staged words, and sets `key_valid` from the next cycle.
- R7: A `dp_rd_en` with index `dp_round` returns that slot on `dp_key` one cycle later, and the value holds until the next read. Index 0 is the master key and index k (1..N_ROUND_KEYS) is round key k. Any larger index returns zero.
- R8: When `power_fail` or `tamper` is high, the next edge zeroes the active bank, the staged copy, the staged-word record and `dp_key`, and clears `key_valid`. This takes precedence over a commit requested in the same cycle, and that commit raises no error.
- R9: `wr_ready` is low whenever `commit_req`, `power_fail` or `tamper` is high. A word presented then is not written and not flagged.
- R10: Word address a = slot*WORDS_PER_KEY + w places its data at bits [w*WORD_W +: WORD_W] of that slot's key, with word 0 least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prov_unlock | input | 1 | Open the provisioning window |
| prov_lock | input | 1 | Close and seal provisioning until reset |
| prov_open | output | 1 | Provisioning window is open |
| wr_valid | input | 1 | Host write word valid |
| wr_ready | output | 1 | Bank can take a write this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | WORD_W | Write data |
| wr_err | output | 1 | Pulse: previous transferred write was rejected |
| host_rd_req | input | 1 | Host read strobe on the key window |
| host_rd_ack | output | 1 | Read answer strobe, one cycle after request |
| host_rd_data | output | WORD_W | Read data, always zero |
| commit_req | input | 1 | Request atomic commit of the staged copy |
| commit_err | output | 1 | Pulse: previous commit was refused |
| key_valid | output | 1 | Active bank holds a committed key |
| power_fail | input | 1 | Power-loss indication, wipes the bank |
| tamper | input | 1 | Tamper alarm, wipes the bank |
| dp_rd_en | input | 1 | Datapath key read enable |
| dp_round | input | IDX_W | Slot index for the datapath read |
| dp_key | output | KEY_W | Registered key for the datapath |

## Verification
The bench aims at the boundaries between staging and activation. It commits with one word missing, holds a write against a commit so that back-pressure blocks it, and reads the datapath port right around a commit. A bank that let partial data through would show a mixed key or accept the short commit. A tamper alarm in the same cycle as a commit must leave `key_valid` low, and a later commit must be refused. A design that let the commit win, or that kept the staged record, would reactivate the key. The bench also writes out-of-range addresses, reads indices past the last slot, and tries to unlock after sealing, where a careless decoder would alias words or reopen the window.

// File: rtl/kb_pkg.sv
package kb_pkg;
  typedef enum logic [1:0] {
    PV_CLOSED = 2'd0,
    PV_OPEN   = 2'd1,
    PV_SEALED = 2'd2
  } prov_state_e;
endpackage

// File: rtl/kb_prov_ctrl.sv
module kb_prov_ctrl
  import kb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic unlock,
  input  logic lock,
  output logic open_o
);
  prov_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PV_CLOSED;
    end else begin
      unique case (st_q)
        PV_CLOSED: if (lock) st_q <= PV_SEALED; else if (unlock) st_q <= PV_OPEN;
        PV_OPEN:   if (lock) st_q <= PV_SEALED;
        default:   st_q <= PV_SEALED;
      endcase
    end
  end

  assign open_o = (st_q == PV_OPEN);
endmodule

// File: rtl/kb_shadow_store.sv
module kb_shadow_store #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 44,
  parameter int ADDR_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wipe,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        clr_staged,
  output logic [N_WORDS*WORD_W-1:0]   shadow_flat,
  output logic                        all_staged
);
  logic [N_WORDS-1:0] staged_q;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic hit;
    logic [WORD_W-1:0] word_q;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (wipe) word_q <= '0;
      else if (hit)  word_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  staged_q[g] <= 1'b0;
      else if (wipe || clr_staged) staged_q[g] <= 1'b0;
      else if (hit)                staged_q[g] <= 1'b1;
    end

    assign shadow_flat[g*WORD_W +: WORD_W] = word_q;
  end

  assign all_staged = &staged_q;
endmodule

// File: rtl/kb_active_store.sv
module kb_active_store #(
  parameter int WORD_W        = 32,
  parameter int WORDS_PER_KEY = 4,
  parameter int N_SLOTS       = 11,
  parameter int IDX_W         = 4,
  localparam int KEY_W        = WORD_W * WORDS_PER_KEY,
  localparam int FLAT_W       = KEY_W * N_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              load,
  input  logic [FLAT_W-1:0] shadow_flat,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [KEY_W-1:0]  rd_key,
  output logic [FLAT_W-1:0] active_flat
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS - 1);

  logic [FLAT_W-1:0] act_q;
  logic [KEY_W-1:0]  slot_view [N_SLOTS];
  logic [KEY_W-1:0]  sel_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (wipe) act_q <= '0;
    else if (load) act_q <= shadow_flat;
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    assign slot_view[s] = act_q[s*KEY_W +: KEY_W];
  end

  always_comb begin
    sel_key = '0;
    if (rd_idx <= LAST_IDX) sel_key = slot_view[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_key <= '0;
    else if (wipe)  rd_key <= '0;
    else if (rd_en) rd_key <= sel_key;
  end

  assign active_flat = act_q;
endmodule

// File: rtl/keyvault_bank.sv
module keyvault_bank #(
  parameter int WORD_W        = 32,
  parameter int WORDS_PER_KEY = 4,
  parameter int N_ROUND_KEYS  = 10,
  localparam int N_SLOTS      = N_ROUND_KEYS + 1,
  localparam int N_WORDS      = N_SLOTS * WORDS_PER_KEY,
  localparam int ADDR_W       = $clog2(N_WORDS),
  localparam int IDX_W        = $clog2(N_SLOTS),
  localparam int KEY_W        = WORD_W * WORDS_PER_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prov_unlock,
  input  logic              prov_lock,
  output logic              prov_open,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_err,
  input  logic              host_rd_req,
  output logic              host_rd_ack,
  output logic [WORD_W-1:0] host_rd_data,
  input  logic              commit_req,
  output logic              commit_err,
  output logic              key_valid,
  input  logic              power_fail,
  input  logic              tamper,
  input  logic              dp_rd_en,
  input  logic [IDX_W-1:0]  dp_round,
  output logic [KEY_W-1:0]  dp_key
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_WORDS - 1);

  logic                      zap;
  logic                      xfer;
  logic                      wr_take;
  logic                      commit_ok;
  logic                      all_staged;
  logic [N_WORDS*WORD_W-1:0] shadow_flat;
  logic [N_WORDS*WORD_W-1:0] active_flat;

  assign zap       = power_fail | tamper;
  assign wr_ready  = ~zap & ~commit_req;
  assign xfer      = wr_valid & wr_ready;
  assign wr_take   = xfer & prov_open & (wr_addr <= LAST_ADDR);
  assign commit_ok = commit_req & ~zap & all_staged;

  kb_prov_ctrl i_prov (
    .clk    (clk),
    .rst_n  (rst_n),
    .unlock (prov_unlock),
    .lock   (prov_lock),
    .open_o (prov_open)
  );

  kb_shadow_store #(
    .WORD_W  (WORD_W),
    .N_WORDS (N_WORDS),
    .ADDR_W  (ADDR_W)
  ) i_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .wipe        (zap),
    .wr_en       (wr_take),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .clr_staged  (commit_ok),
    .shadow_flat (shadow_flat),
    .all_staged  (all_staged)
  );

  kb_active_store #(
    .WORD_W        (WORD_W),
    .WORDS_PER_KEY (WORDS_PER_KEY),
    .N_SLOTS       (N_SLOTS),
    .IDX_W         (IDX_W)
  ) i_active (
    .clk         (clk),
    .rst_n       (rst_n),
    .wipe        (zap),
    .load        (commit_ok),
    .shadow_flat (shadow_flat),
    .rd_en       (dp_rd_en),
    .rd_idx      (dp_round),
    .rd_key      (dp_key),
    .active_flat (active_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_err      <= 1'b0;
      commit_err  <= 1'b0;
      key_valid   <= 1'b0;
      host_rd_ack <= 1'b0;
    end else begin
      wr_err      <= xfer & ~wr_take;
      commit_err  <= commit_req & ~zap & ~all_staged;
      host_rd_ack <= host_rd_req;
      if (zap)            key_valid <= 1'b0;
      else if (commit_ok) key_valid <= 1'b1;
    end
  end

  assign host_rd_data = '0;
endmodule

// File: rtl/kb_checker.sv
module kb_checker #(
  parameter int FLAT_W = 1408,
  parameter int KEY_W  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prov_lock,
  input logic              prov_open,
  input logic              xfer,
  input logic              wr_valid,
  input logic              wr_err,
  input logic              commit_req,
  input logic              commit_err,
  input logic              key_valid,
  input logic              power_fail,
  input logic              tamper,
  input logic [KEY_W-1:0]  dp_key,
  input logic [FLAT_W-1:0] active_flat
);
  p_sealed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prov_lock |=> !prov_open);

  p_closed_write_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !prov_open) |=> wr_err);

  p_refused_keeps_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_err |-> $stable(active_flat));

  p_valid_needs_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> $past(commit_req));

  p_blank_when_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_valid && $past(!key_valid)) |-> (dp_key == '0));

  p_wipe_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (power_fail || tamper) |=> (!key_valid && active_flat == '0));

  p_blocked_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (commit_req || power_fail || tamper)) |=> !wr_err);
endmodule

bind keyvault_bank kb_checker #(
  .FLAT_W (N_WORDS * WORD_W),
  .KEY_W  (KEY_W)
) i_kb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .prov_lock   (prov_lock),
  .prov_open   (prov_open),
  .xfer        (xfer),
  .wr_valid    (wr_valid),
  .wr_err      (wr_err),
  .commit_req  (commit_req),
  .commit_err  (commit_err),
  .key_valid   (key_valid),
  .power_fail  (power_fail),
  .tamper      (tamper),
  .dp_key      (dp_key),
  .active_flat (active_flat)
);

// File: tb/test_keyvault_bank.sv
`timescale 1ns/1ps
module test_keyvault_bank;
  localparam int WW = 32;
  localparam int WPK = 4;
  localparam int NS = 11;
  localparam int NW = NS * WPK;
  localparam int AW = 6;
  localparam int IW = 4;
  localparam int KW = WW * WPK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prov_unlock = 0, prov_lock = 0, wr_valid = 0, host_rd_req = 0;
  logic commit_req = 0, power_fail = 0, tamper = 0, dp_rd_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [IW-1:0] dp_round = '0;
  logic prov_open, wr_ready, wr_err, host_rd_ack, commit_err, key_valid;
  logic [WW-1:0] host_rd_data;
  logic [KW-1:0] dp_key;

  always #4 clk = ~clk;

  keyvault_bank i_keyvault_bank (.*);

  int n_chk = 0, n_bad = 0;
  logic [WW-1:0] m_shadow [NW];
  logic [WW-1:0] m_active [NW];
  bit m_staged [NW];
  bit m_valid = 0, m_open = 0;

  task automatic check(bit ok, string req, string what, logic [KW-1:0] act, logic [KW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] exp_slot(int s);
    logic [KW-1:0] k = '0;
    if (s < NS) for (int w = 0; w < WPK; w++) k[w*WW +: WW] = m_active[s*WPK + w];
    return k;
  endfunction

  function automatic bit all_staged();
    for (int i = 0; i < NW; i++) if (!m_staged[i]) return 0;
    return 1;
  endfunction

  function automatic void model_wipe();
    for (int i = 0; i < NW; i++) begin
      m_shadow[i] = '0; m_active[i] = '0; m_staged[i] = 0;
    end
    m_valid = 0;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(int a, logic [WW-1:0] d);
    bit acc;
    wr_valid = 1; wr_addr = AW'(a); wr_data = d;
    step();
    wr_valid = 0;
    acc = m_open && (a < NW);
    check(wr_err == !acc, "R3", "wr_err", KW'(wr_err), KW'(!acc));
    if (acc) begin m_shadow[a] = d; m_staged[a] = 1; end
  endtask

  task automatic do_commit();
    bit ok = all_staged();
    commit_req = 1;
    step();
    commit_req = 0;
    check(commit_err == !ok, "R5", "commit_err", KW'(commit_err), KW'(!ok));
    if (ok) begin
      for (int i = 0; i < NW; i++) begin m_active[i] = m_shadow[i]; m_staged[i] = 0; end
      m_valid = 1;
    end
    check(key_valid == m_valid, "R6", "key_valid", KW'(key_valid), KW'(m_valid));
  endtask

  task automatic dp_check(int idx, string req);
    dp_rd_en = 1; dp_round = IW'(idx);
    step();
    dp_rd_en = 0;
    check(dp_key == exp_slot(idx), req, "dp_key", dp_key, exp_slot(idx));
  endtask

  task automatic fill_all(int skip);
    for (int i = 0; i < NW; i++) if (i != skip) do_write(i, $urandom);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    model_wipe();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    check(!prov_open && !key_valid && !wr_err && !commit_err && !host_rd_ack, "R1",
          "flags", KW'({prov_open, key_valid, wr_err, commit_err, host_rd_ack}), '0);
    check(dp_key == '0, "R1", "dp_key", dp_key, '0);

    // R3 write while closed
    do_write(5, 32'hdead_beef);
    // R2 unlock
    prov_unlock = 1; step(); prov_unlock = 0; m_open = 1;
    check(prov_open, "R2", "prov_open after unlock", KW'(prov_open), KW'(1));
    // R5 commit with nothing staged
    do_commit();
    dp_check(0, "R7");

    // stage all but last, refused, then full commit
    fill_all(NW - 1);
    do_commit();
    dp_check(1, "R5");
    do_write(NW - 1, $urandom);
    do_commit();
    for (int s = 0; s < NS + 2; s++) dp_check(s, "R7");
    // R10 explicit word order for slot 3
    dp_rd_en = 1; dp_round = 3; step(); dp_rd_en = 0;
    check(dp_key[WW-1:0] == m_active[12] && dp_key[KW-1 -: WW] == m_active[15], "R10",
          "word order", dp_key, exp_slot(3));
    // R7 hold value when not enabled
    dp_round = 0; step();
    check(dp_key == exp_slot(3), "R7", "hold", dp_key, exp_slot(3));

    // R3 out-of-range address
    do_write(NW, 32'h1234_5678);
    do_write(63, 32'h1);

    // R4 host read
    host_rd_req = 1; step(); host_rd_req = 0;
    check(host_rd_ack && host_rd_data == '0, "R4", "host read", KW'(host_rd_data), '0);
    step();
    check(!host_rd_ack, "R4", "ack pulse", KW'(host_rd_ack), '0);

    // R9 write held against commit
    fill_all(-1);
    wr_valid = 1; wr_addr = 7; wr_data = 32'hcafe_f00d; commit_req = 1; #1;
    check(!wr_ready, "R9", "wr_ready during commit", KW'(wr_ready), '0);
    step();
    commit_req = 0; wr_valid = 0;
    for (int i = 0; i < NW; i++) begin m_active[i] = m_shadow[i]; m_staged[i] = 0; end
    m_valid = 1;
    check(!wr_err && !commit_err && key_valid, "R9", "commit with held write",
          KW'({wr_err, commit_err, key_valid}), KW'(1));
    fill_all(7);
    do_commit();   // word 7 never staged: refused
    dp_check(1, "R6");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int r = $urandom_range(0, 9);
      if (r < 6)      do_write($urandom_range(0, NW + 3), $urandom);
      else if (r < 7) do_commit();
      else            dp_check($urandom_range(0, NS + 2), "R7");
      if (it % 150 == 149) begin fill_all(-1); do_commit(); end
    end

    // R8 tamper with commit in same cycle
    fill_all(-1);
    commit_req = 1; tamper = 1; wr_valid = 1; wr_addr = 2; #1;
    check(!wr_ready, "R9", "wr_ready during tamper", KW'(wr_ready), '0);
    step();
    commit_req = 0; tamper = 0; wr_valid = 0;
    model_wipe();
    check(!key_valid && !commit_err && !wr_err, "R8", "after tamper",
          KW'({key_valid, commit_err, wr_err}), '0);
    for (int s = 0; s < NS; s++) dp_check(s, "R8");
    do_commit();   // staged record discarded: refused

    // R8 power fail after a good commit
    fill_all(-1); do_commit();
    dp_check(4, "R6");
    dp_rd_en = 1; dp_round = 4; power_fail = 1; step(); power_fail = 0; dp_rd_en = 0;
    model_wipe();
    check(!key_valid && dp_key == '0, "R8", "after power fail", dp_key, '0);
    dp_check(4, "R8");

    // R2 lock, then unlock ignored
    prov_lock = 1; prov_unlock = 1; step(); prov_lock = 0; prov_unlock = 0; m_open = 0;
    check(!prov_open, "R2", "locked", KW'(prov_open), '0);
    do_write(0, 32'h5);
    prov_unlock = 1; step(); prov_unlock = 0;
    check(!prov_open, "R2", "unlock after seal", KW'(prov_open), '0);
    do_write(1, 32'h6);

    finish_run();
  end
endmodule